// File: doc/BRIEF.md
# Sequential Fractional Multiply-Divide Unit

This unit performs multiplication and division on signed two's-complement fractions of `W` bits (sign plus `W-1` fraction bits, default 20), one result bit per clock. A double-length value is formed from an upper word A, which carries the sign, and a lower word R, whose top bit plays no part in the value. Together they give a `2W-1` bit signed fraction. There are four operations. Two are multiplies: one keeps the full double-length product, the other rounds it to a single word. Two are divides of the double-length A:R by a single-length divisor: one keeps the quotient and remainder, the other rounds the quotient.

A host presents the operation code and the three operands, then pulses `start`. The unit captures them and raises `busy` while it iterates. After the last step it writes the result words and the overflow flag in one cycle, and it marks that cycle with a single-cycle `done` pulse. Division first checks that the quotient can fit at all. A zero divisor, or a quotient of magnitude two or more, ends the operation at once.

Top module: `frac_mdu`

## Requirements
- R1: `start` is accepted only on a clock edge where `busy` is low. `busy` is high from the following cycle until the result is written. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R2: `done` rises the given number of cycles after the accepting edge: `W+1` for op codes 0, 1 and 2; `W+2` for op code 3; one cycle for a divide with a zero divisor or with a quotient of magnitude at least two.
- R3: A `start` raised while `busy` is high has no effect: the running operation completes with its own operands, and no second `done` follows.
- R4: Op code 0 (full multiply) forms p = A·B as a signed integer of units 2^-(2W-2). `a_out` receives bits [2W-2:W-1] of p, and `r_out` receives a zero top bit above bits [W-2:0] of p.
- R5: A multiply sets `ovf` only when both operands are -1. In that case op code 0 returns `a_out` = 1 followed by zeros and `r_out` = 0.
- R6: Op code 1 (rounded multiply) returns floor((p + 2^(W-2)) / 2^(W-1)) in `a_out` and 0 in `r_out`. `ovf` is set when that value exceeds 2^(W-1)-1.
- R7: Op code 2 (divide with remainder) takes the dividend D = {A, R[W-2:0]} and ignores the top bit of R. The quotient is truncated toward zero and placed in `r_out`. The remainder rem is placed in `a_out` and satisfies D = Q·B + rem. When rem is nonzero it has the sign of D.
- R8: Op code 3 (rounded divide) returns sign·floor((2|D|/|B| + 1) / 2) in `a_out`, where the sign is negative when D and B differ in sign. This is round half away from zero. `r_out` returns 0.
- R9: A divide whose quotient lies outside [-2^(W-1), 2^(W-1)-1] (in units of 2^-(W-1)) sets `ovf` and returns the captured A and R unchanged.
- R10: A divide by zero always sets `ovf` and returns the captured A and R unchanged.
- R11: After reset `busy`, `done`, `ovf`, `a_out` and `r_out` are all zero.
- R12: `ovf`, `a_out` and `r_out` hold the last result until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | 0 full multiply, 1 rounded multiply, 2 divide with remainder, 3 rounded divide |
| a_in | input | W | Upper word A (multiplicand or dividend high half) |
| r_in | input | W | Lower word R (dividend low half; top bit ignored) |
| b_in | input | W | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| ovf | output | 1 | Overflow of the last completed operation |
| a_out | output | W | Result word A |
| r_out | output | W | Result word R |

## Verification
The hardest situations to reach are at the scaling boundaries. These are -1 × -1, quotients of exactly +1 or -1, rounding ties, and dividends whose high half already reaches the divisor, which take the one-cycle early exit. Random stimulus almost never produces them. The bench therefore uses `W = 5`. It sweeps every operand pair for both multiplies. For both divides it combines every divisor with a strided set of dividends, and it adds the largest and smallest dividends and ±2^-(2W-2). This places the quotient-range edges and the half-way ties inside the sweep. The ignored R sign bit is toggled across the sweep, and a separate sequence holds `start` high during a run.

// File: rtl/frac_mdu_pkg.sv
`timescale 1ns/1ps
package frac_mdu_pkg;

   typedef enum logic [1:0] {
      OP_MUL_DBL = 2'd0,
      OP_MUL_RND = 2'd1,
      OP_DIV_REM = 2'd2,
      OP_DIV_RND = 2'd3
   } mdu_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } mdu_st_e;

endpackage

// File: rtl/frac_mul_core.sv
`timescale 1ns/1ps
// Unsigned shift-add multiplier, multiplier consumed MSB first, one bit per step.
module frac_mul_core #(
   parameter int W = 20
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld,
   input  logic           step,
   input  logic [W-1:0]   mcand,
   input  logic [W-1:0]   mplier,
   output logic [2*W-1:0] prod
);
   localparam int PW = 2*W;

   logic [PW-1:0] acc;
   logic [W-1:0]  mc;
   logic [W-1:0]  mq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         mc  <= '0;
         mq  <= '0;
      end else if (ld) begin
         acc <= '0;
         mc  <= mcand;
         mq  <= mplier;
      end else if (step) begin
         acc <= {acc[PW-2:0], 1'b0} + (mq[W-1] ? {{W{1'b0}}, mc} : {PW{1'b0}});
         mq  <= {mq[W-2:0], 1'b0};
      end
   end

   assign prod = acc;

   // R4
   mul_acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (acc <= ({{W{1'b0}}, mc} << W)));

endmodule

// File: rtl/frac_div_core.sv
`timescale 1ns/1ps
// Restoring divider on magnitudes. The dividend's upper part seeds the partial
// remainder; the low W bits (plus one zero for the rounding bit) are shifted in.
module frac_div_core #(
   parameter int W = 20
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld,
   input  logic           step,
   input  logic [2*W-2:0] num,
   input  logic [W-1:0]   den,
   output logic           early_ovf,
   output logic [W:0]     quo,
   output logic [W-1:0]   rem
);
   logic [W-2:0] hi;
   logic [W-1:0] rem_q;
   logic [W:0]   low_q;
   logic [W:0]   quo_q;
   logic [W-1:0] den_q;
   logic [W:0]   trial;
   logic         fits;
   logic [W-1:0] diff;

   assign hi        = num[2*W-2:W];
   assign early_ovf = ({1'b0, hi} >= den);

   always_comb begin
      trial = {rem_q, low_q[W]};
      fits  = (trial >= {1'b0, den_q});
      diff  = trial[W-1:0] - den_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         low_q <= '0;
         quo_q <= '0;
         den_q <= '0;
      end else if (ld) begin
         rem_q <= {1'b0, hi};
         low_q <= {num[W-1:0], 1'b0};
         quo_q <= '0;
         den_q <= den;
      end else if (step) begin
         rem_q <= fits ? diff : trial[W-1:0];
         low_q <= {low_q[W-1:0], 1'b0};
         quo_q <= {quo_q[W-1:0], fits};
      end
   end

   assign quo = quo_q;
   assign rem = rem_q;

   // R7
   rem_below_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (rem_q < den_q));

endmodule

// File: rtl/frac_mdu.sv
`timescale 1ns/1ps
module frac_mdu
   import frac_mdu_pkg::*;
#(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [1:0]   op,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] r_in,
   input  logic [W-1:0] b_in,
   output logic         busy,
   output logic         done,
   output logic         ovf,
   output logic [W-1:0] a_out,
   output logic [W-1:0] r_out
);
   localparam int DW = 2*W-1;
   localparam int PW = 2*W;
   localparam int CW = $clog2(W+2);
   localparam logic [W-1:0] MINV  = {1'b1, {(W-1){1'b0}}};
   localparam logic [W:0]   HALFQ = {2'b01, {(W-1){1'b0}}};

   if (W < 3) begin : g_width_check
      $error("frac_mdu: W must be at least 3");
   end

   mdu_st_e       st;
   mdu_op_e       op_q;
   logic [W-1:0]  a_q, r_q, b_q;
   logic          neg_q, eovf_q;
   logic [CW-1:0] cnt;

   logic          accept, run;
   logic [W-1:0]  a_mag, b_mag;
   logic [DW-1:0] dvd, dvd_mag;
   logic [PW-1:0] prod, p;
   logic [W:0]    pr_hi;
   logic          div_early;
   logic [W:0]    quo, qm;
   logic [W-1:0]  rem, qs, rs;
   logic          q_ovf;
   logic [W-1:0]  a_res, r_res;
   logic          ovf_res;

   assign accept = start && (st == ST_IDLE);
   assign run    = (st == ST_RUN);
   assign busy   = (st != ST_IDLE);

   always_comb begin
      a_mag   = a_in[W-1] ? (~a_in + 1'b1) : a_in;
      b_mag   = b_in[W-1] ? (~b_in + 1'b1) : b_in;
      dvd     = {a_in, r_in[W-2:0]};
      dvd_mag = dvd[DW-1] ? (~dvd + 1'b1) : dvd;
   end

   frac_mul_core #(.W(W)) u_mul (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (accept && !op[1]),
      .step   (run && !op_q[1]),
      .mcand  (a_mag),
      .mplier (b_mag),
      .prod   (prod)
   );

   frac_div_core #(.W(W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld        (accept && op[1]),
      .step      (run && op_q[1]),
      .num       (dvd_mag),
      .den       (b_mag),
      .early_ovf (div_early),
      .quo       (quo),
      .rem       (rem)
   );

   // Result formatting: sign restore, rounding, range check.
   always_comb begin
      p     = neg_q ? (~prod + 1'b1) : prod;
      pr_hi = p[PW-1:W-1] + {{W{1'b0}}, p[W-2]};
      qm    = (op_q == OP_DIV_RND) ? ({1'b0, quo[W:1]} + {{W{1'b0}}, quo[0]}) : quo;
      q_ovf = eovf_q | (neg_q ? (qm > HALFQ) : (qm >= HALFQ));
      qs    = neg_q ? (~qm[W-1:0] + 1'b1) : qm[W-1:0];
      rs    = a_q[W-1] ? (~rem + 1'b1) : rem;
      a_res   = a_q;
      r_res   = r_q;
      ovf_res = q_ovf;
      case (op_q)
         OP_MUL_DBL: begin
            a_res   = p[DW-1:W-1];
            r_res   = {1'b0, p[W-2:0]};
            ovf_res = !p[PW-1] && p[PW-2];
         end
         OP_MUL_RND: begin
            a_res   = pr_hi[W-1:0];
            r_res   = '0;
            ovf_res = !pr_hi[W] && pr_hi[W-1];
         end
         OP_DIV_REM: begin
            if (!q_ovf) begin
               a_res = rs;
               r_res = qs;
            end
         end
         OP_DIV_RND: begin
            if (!q_ovf) begin
               a_res = qs;
               r_res = '0;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         op_q   <= OP_MUL_DBL;
         a_q    <= '0;
         r_q    <= '0;
         b_q    <= '0;
         neg_q  <= 1'b0;
         eovf_q <= 1'b0;
         cnt    <= '0;
         done   <= 1'b0;
         ovf    <= 1'b0;
         a_out  <= '0;
         r_out  <= '0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (accept) begin
                  op_q  <= mdu_op_e'(op);
                  a_q   <= a_in;
                  r_q   <= r_in;
                  b_q   <= b_in;
                  neg_q <= a_in[W-1] ^ b_in[W-1];
                  cnt   <= (op == 2'd3) ? CW'(W+1) : CW'(W);
                  if (op[1] && div_early) begin
                     st     <= ST_FIN;
                     eovf_q <= 1'b1;
                  end else begin
                     st     <= ST_RUN;
                     eovf_q <= 1'b0;
                  end
               end
            end
            ST_RUN: begin
               cnt <= cnt - 1'b1;
               if (cnt == CW'(1)) st <= ST_FIN;
            end
            ST_FIN: begin
               st    <= ST_IDLE;
               done  <= 1'b1;
               a_out <= a_res;
               r_out <= r_res;
               ovf   <= ovf_res;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R1
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R5
   mul_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !op_q[1] && ovf) |-> (a_q == MINV && b_q == MINV));
   // R10
   div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q[1] && b_q == '0) |-> (ovf && a_out == a_q && r_out == r_q));
   // R4
   rsign_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == OP_MUL_DBL) |-> !r_out[W-1]);
   // R6
   mulrnd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == OP_MUL_RND) |-> (r_out == '0));
   // R8
   divrnd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == OP_DIV_RND && !ovf) |-> (r_out == '0));
   // R7
   rem_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == OP_DIV_REM && !ovf && a_out != '0) |-> (a_out[W-1] == a_q[W-1]));

endmodule

// File: tb/tb_frac_mdu.sv
`timescale 1ns/1ps
module tb_frac_mdu;
   localparam int W = 5;
   localparam longint HALF = longint'(1) << (W-1);
   localparam longint MASK = (longint'(1) << W) - 1;
   localparam longint DMAX = longint'(1) << (2*W-2);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [1:0]   op = 2'd0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] r_in = '0;
   logic [W-1:0] b_in = '0;
   logic         busy, done, ovf;
   logic [W-1:0] a_out, r_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   frac_mdu #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .a_in(a_in), .r_in(r_in), .b_in(b_in),
      .busy(busy), .done(done), .ovf(ovf), .a_out(a_out), .r_out(r_out)
   );

   task automatic check(input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   function automatic longint sx(input logic [W-1:0] v);
      return v[W-1] ? longint'(v) - (longint'(1) << W) : longint'(v);
   endfunction

   task automatic model(input int opc, input logic [W-1:0] a, input logic [W-1:0] r,
                        input logic [W-1:0] b, output longint ea, output longint er,
                        output longint eo, output longint el);
      longint ai, bi, p, pr, d, dm, bm, qm, q, rm;
      bit negd, neg;
      ai = sx(a);
      bi = sx(b);
      qm = 0;
      if (opc < 2) begin
         p  = ai * bi;
         el = W + 1;
         if (opc == 0) begin
            ea = (p >>> (W-1)) & MASK;
            er = p & (HALF - 1);
            eo = (p == DMAX) ? 1 : 0;
         end else begin
            pr = (p + (longint'(1) << (W-2))) >>> (W-1);
            ea = pr & MASK;
            er = 0;
            eo = (pr > HALF - 1) ? 1 : 0;
         end
      end else begin
         d    = ai * HALF + (longint'(r) & (HALF - 1));
         negd = (d < 0);
         dm   = negd ? -d : d;
         bm   = (bi < 0) ? -bi : bi;
         neg  = negd != (bi < 0);
         eo   = 0;
         el   = (opc == 3) ? W + 2 : W + 1;
         if (bm == 0 || dm / bm >= (longint'(1) << W)) begin
            eo = 1;
            el = 1;
         end else begin
            qm = (opc == 2) ? dm / bm : ((2 * dm) / bm + 1) / 2;
            eo = (neg ? (qm > HALF) : (qm > HALF - 1)) ? 1 : 0;
         end
         if (eo != 0) begin
            ea = longint'(a);
            er = longint'(r);
         end else begin
            q = neg ? -qm : qm;
            if (opc == 2) begin
               rm = dm - qm * bm;
               if (negd) rm = -rm;
               ea = rm & MASK;
               er = q & MASK;
            end else begin
               ea = q & MASK;
               er = 0;
            end
         end
      end
   endtask

   task automatic run_op(input int opc, input logic [W-1:0] a, input logic [W-1:0] r,
                         input logic [W-1:0] b, output longint lat);
      @(negedge clk);
      op = 2'(opc); a_in = a; r_in = r; b_in = b; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      do begin
         @(posedge clk); #1;
         lat++;
      end while (!done && lat < 64);
   endtask

   task automatic test(input int opc, input logic [W-1:0] a, input logic [W-1:0] r,
                       input logic [W-1:0] b);
      longint lat, ea, er, eo, el;
      string rq, ro, ctx;
      rq = (opc == 0) ? "R4" : (opc == 1) ? "R6" : (opc == 2) ? "R7" : "R8";
      ro = (opc < 2) ? "R5" : ((b == '0) ? "R10" : "R9");
      run_op(opc, a, r, b, lat);
      model(opc, a, r, b, ea, er, eo, el);
      ctx = $sformatf("op%0d a=%0d r=%0d b=%0d", opc, a, r, b);
      check({rq, " a_out ", ctx}, longint'(a_out), ea);
      check({rq, " r_out ", ctx}, longint'(r_out), er);
      check({ro, " ovf ", ctx}, longint'(ovf), eo);
      check({"R2 latency ", ctx}, lat, el);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      longint lat, ea, er, eo, el;
      int extra_done;
      int bnd[4];

      // R11 reset state
      repeat (3) @(posedge clk);
      #1;
      check("R11 busy", longint'(busy), 0);
      check("R11 done", longint'(done), 0);
      check("R11 ovf", longint'(ovf), 0);
      check("R11 a_out", longint'(a_out), 0);
      check("R11 r_out", longint'(r_out), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // Multiply: every operand pair, both variants (R4 R5 R6)
      for (int ia = 0; ia < (1 << W); ia++)
         for (int ib = 0; ib < (1 << W); ib++)
            for (int o = 0; o < 2; o++)
               test(o, W'(ia), W'(ia ^ ib), W'(ib));

      // Divide: strided dividends, all divisors, R sign bit toggled (R7 R8 R9 R10)
      for (int dv = -(1 << (2*W-2)); dv < (1 << (2*W-2)); dv += 3)
         for (int ib = 0; ib < (1 << W); ib++)
            for (int o = 2; o < 4; o++)
               test(o, W'(dv >>> (W-1)),
                    W'((dv & ((1 << (W-1)) - 1)) | (((dv + ib) & 1) << (W-1))), W'(ib));

      // Divide boundary dividends (R7 R8 R9)
      bnd = '{(1 << (2*W-2)) - 1, -(1 << (2*W-2)), 1, -1};
      foreach (bnd[k])
         for (int ib = 0; ib < (1 << W); ib++)
            for (int o = 2; o < 4; o++)
               test(o, W'(bnd[k] >>> (W-1)), W'(bnd[k] & ((1 << (W-1)) - 1)), W'(ib));

      // R1 R3: start held high during a run is ignored
      @(negedge clk);
      op = 2'd0; a_in = W'(3); r_in = '0; b_in = W'(5); start = 1'b1;
      @(posedge clk); #1;
      check("R1 busy after accept", longint'(busy), 1);
      @(negedge clk);
      op = 2'd2; a_in = W'(7); b_in = '0;
      repeat (2) @(negedge clk);
      start = 1'b0;
      lat = 2;
      do begin
         @(posedge clk); #1;
         lat++;
      end while (!done && lat < 64);
      model(0, W'(3), W'(0), W'(5), ea, er, eo, el);
      check("R3 a_out keeps first op", longint'(a_out), ea);
      check("R3 r_out keeps first op", longint'(r_out), er);
      check("R3 latency unchanged", lat, el);
      check("R1 busy low with done", longint'(busy), 0);
      extra_done = 0;
      for (int c = 0; c < 8; c++) begin
         @(posedge clk); #1;
         if (done) extra_done++;
      end
      check("R1 R3 no further done", longint'(extra_done), 0);
      check("R3 busy stays low", longint'(busy), 0);

      // R12: overflow flag and words hold until the next result
      test(3, W'(9), W'(4), W'(0));
      repeat (5) @(posedge clk);
      #1;
      check("R12 ovf held", longint'(ovf), 1);
      check("R12 a_out held", longint'(a_out), 9);
      check("R12 r_out held", longint'(r_out), 4);
      test(0, W'(2), W'(0), W'(3));
      check("R12 ovf cleared by next op", longint'(ovf), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule